// File: doc/BRIEF.md
# Printer Port Register Interface

This block is the register-level controller of a standard-mode printer port. Three byte registers sit on a small register bus: an outgoing data byte, a status byte and a control byte. A fourth input, the reverse data bus, supplies the byte returned when the port is turned around for input. The block also plays the printer's side of the handshake internally. Pulses on the strobe control bit and successive status reads walk the busy and acknowledge status bits through a fixed sequence. Each character that the strobe releases leaves on a byte output channel.

The register bus uses single-cycle strobes. A write takes effect at the clock edge where `bus_wr` is sampled. A read returns its data on `bus_rdata` in the cycle after `bus_rd` and holds it until the next read. The character channel is a push-only stream. `chr_valid` is high for exactly one cycle per character, and `chr_data` is meaningful in that cycle. There is no ready input and no back-pressure, so the sink must take every byte in the cycle it is offered. The interrupt output is a level.

Control bits: 5 direction (1 = input), 4 interrupt enable, 3 select, 2 init (active high = run), 1 auto-feed, 0 strobe. Status bits: 7 not-busy, 6 acknowledge, 5 paper-out, 4 online, 3 not-error, 0 timeout. Offsets: 0 data, 1 status, 2 control.

Top module: `pport_ctrl`

## Requirements
- R1: After reset the data register reads 0xFF, status reads 0xD9, control reads 0xCC, `irq` is 0, `chr_valid` is 0 and `bus_rdata` is 0xFF.
- R2: Every write to offset 2 stores the written byte with bits 7 and 6 forced to 1, and reading offset 2 returns the stored byte.
- R3: A control write with bit 2 = 0 loads status with 0xD8 (not-busy, acknowledge, online and not-error set; paper-out and timeout clear).
- R4: A control write with bits 2, 3 and 0 all 1 clears status bit 7. If the previously stored bit 0 was 0, the data register is also presented on `chr_data` with `chr_valid` high for exactly the next cycle. If the previous bit 0 was 1, nothing is emitted.
- R5: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 0 sets the interrupt-pending flag, but only if the previously stored control had bit 4 set.
- R6: A read of offset 1 returns status as it was before the read and clears the interrupt-pending flag. If status bit 7 is 0 and stored control bit 0 is 0, the read then clears bit 6 when bit 6 was set, or sets bits 6 and 7 when bit 6 was clear.
- R7: A read of offset 0 returns `rev_data` when control bit 5 is 1, and the data register otherwise.
- R8: Reads of offsets 3 to 7 return 0xFF. Writes to offsets 1 and 3 to 7 change no register.
- R9: `bus_rdata` updates only in the cycle after an accepted read and holds otherwise. A read strobe in the same cycle as a write strobe is ignored, and the write is taken.
- R10: `irq` equals the interrupt-pending flag. A data write leaves it unchanged.
- R11: A control write with bit 2 = 1 and bit 3 = 0 stores the control byte but leaves status unchanged and emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rev_data | input | 8 | Reverse-direction input byte |
| chr_valid | output | 1 | One-cycle pulse for each emitted character |
| chr_data | output | 8 | Emitted character |
| irq | output | 1 | Interrupt level |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it. Register changes, the `chr_valid` pulse, the `irq` change and new `bus_rdata` all land at the edge that samples the strobe. Each bench task drives a strobe for one cycle from the falling edge. It samples the outputs at the falling edge right after the sampling rising edge, so a one-cycle pulse is caught in the only cycle it exists. Hold and no-effect checks sample again one or more cycles later, after idle edges, so a late or lingering change still shows.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int unsigned BYTE_W = 8;

  // register offsets
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_CTRL = 2;

  // control bit positions
  localparam int unsigned CB_DIR  = 5;
  localparam int unsigned CB_IEN  = 4;
  localparam int unsigned CB_SEL  = 3;
  localparam int unsigned CB_INIT = 2;
  localparam int unsigned CB_STB  = 0;

  // status bit positions
  localparam int unsigned SB_NBUSY = 7;
  localparam int unsigned SB_ACK   = 6;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t CTRL_FORCE = 8'hC0;
  localparam byte_t RST_DATA   = 8'hFF;
  localparam byte_t RST_STAT   = 8'hD9;
  localparam byte_t RST_CTRL   = 8'hCC;
  localparam byte_t INIT_STAT  = 8'hD8;
  localparam byte_t IDLE_READ  = 8'hFF;

  typedef struct packed {
    logic wr_data;
    logic wr_ctrl;
    logic rd_any;
    logic rd_stat;
  } acc_t;
endpackage

// File: rtl/pport_decode.sv
module pport_decode
  import pport_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output acc_t              acc
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  always_comb begin
    acc.wr_data = bus_wr && (bus_addr == A_DATA);
    acc.wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    // a write in the same cycle wins; the read is dropped
    acc.rd_any  = bus_rd && !bus_wr;
    acc.rd_stat = bus_rd && !bus_wr && (bus_addr == A_STAT);
  end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_data,
  input  logic  wr_ctrl,
  input  byte_t wdata,
  output byte_t data_q,
  output byte_t ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= RST_DATA;
      ctrl_q <= RST_CTRL;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata | CTRL_FORCE;
    end
  end
endmodule

// File: rtl/pport_hshake.sv
module pport_hshake
  import pport_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ctrl,
  input  logic  new_init,
  input  logic  new_sel,
  input  logic  new_stb,
  input  logic  old_ien,
  input  logic  old_stb,
  input  logic  rd_stat,
  input  byte_t data_q,
  output byte_t stat_q,
  output logic  irq,
  output logic  chr_valid,
  output byte_t chr_data
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= RST_STAT;
      pend_q    <= 1'b0;
      chr_valid <= 1'b0;
      chr_data  <= RST_DATA;
    end else begin
      chr_valid <= 1'b0;
      if (wr_ctrl) begin
        if (!new_init) begin
          stat_q <= INIT_STAT;
        end else if (new_sel) begin
          if (new_stb) begin
            stat_q[SB_NBUSY] <= 1'b0;
            if (!old_stb) begin
              chr_valid <= 1'b1;
              chr_data  <= data_q;
            end
          end else if (old_ien) begin
            pend_q <= 1'b1;
          end
        end
      end else if (rd_stat) begin
        pend_q <= 1'b0;
        if (!stat_q[SB_NBUSY] && !old_stb) begin
          if (stat_q[SB_ACK]) begin
            stat_q[SB_ACK] <= 1'b0;
          end else begin
            stat_q[SB_ACK]   <= 1'b1;
            stat_q[SB_NBUSY] <= 1'b1;
          end
        end
      end
    end
  end

  assign irq = pend_q;
endmodule

// File: rtl/pport_rdback.sv
module pport_rdback
  import pport_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_any,
  input  logic [ADDR_W-1:0] bus_addr,
  input  byte_t             data_q,
  input  byte_t             rev_data,
  input  byte_t             stat_q,
  input  byte_t             ctrl_q,
  output byte_t             rdata
);
  byte_t sel;

  always_comb begin
    if (bus_addr == ADDR_W'(OFS_DATA))
      sel = ctrl_q[CB_DIR] ? rev_data : data_q;
    else if (bus_addr == ADDR_W'(OFS_STAT))
      sel = stat_q;
    else if (bus_addr == ADDR_W'(OFS_CTRL))
      sel = ctrl_q;
    else
      sel = IDLE_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= IDLE_READ;
    else if (rd_any) rdata <= sel;
  end
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        rev_data,
  output logic              chr_valid,
  output logic [7:0]        chr_data,
  output logic              irq
);
  acc_t  acc;
  byte_t data_q, ctrl_q, stat_q;

  pport_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .acc(acc)
  );

  pport_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data(acc.wr_data), .wr_ctrl(acc.wr_ctrl),
    .wdata(bus_wdata), .data_q(data_q), .ctrl_q(ctrl_q)
  );

  pport_hshake u_hs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(acc.wr_ctrl),
    .new_init(bus_wdata[CB_INIT]), .new_sel(bus_wdata[CB_SEL]),
    .new_stb(bus_wdata[CB_STB]), .old_ien(ctrl_q[CB_IEN]),
    .old_stb(ctrl_q[CB_STB]), .rd_stat(acc.rd_stat), .data_q(data_q),
    .stat_q(stat_q), .irq(irq), .chr_valid(chr_valid), .chr_data(chr_data)
  );

  pport_rdback #(.ADDR_W(ADDR_W)) u_rb (
    .clk(clk), .rst_n(rst_n), .rd_any(acc.rd_any), .bus_addr(bus_addr),
    .data_q(data_q), .rev_data(rev_data), .stat_q(stat_q), .ctrl_q(ctrl_q),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/pport_ctrl_chk.sv
module pport_ctrl_chk #(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              chr_valid,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);

  a_r4_emit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid |-> $past(bus_wr && bus_addr == A_CTRL &&
                        bus_wdata[0] && bus_wdata[2] && bus_wdata[3]));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid |=> !chr_valid);

  a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(bus_wr && bus_addr == A_CTRL && !bus_wdata[0]));

  a_r6_stat_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == A_STAT) |=> !irq);

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && !bus_wr) |=> $stable(bus_rdata));

  a_r2_ctrl_top_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && !bus_wr && bus_addr == A_CTRL) |-> bus_rdata[7:6] == 2'b11);
endmodule

bind pport_ctrl pport_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .chr_valid(chr_valid), .irq(irq)
);

// File: tb/sim_pport_ctrl.sv
`timescale 1ns/100ps
module sim_pport_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, rev_data = 8'h3A;
  logic [7:0] bus_rdata, chr_data;
  logic       chr_valid, irq;

  int checks = 0, errors = 0;
  logic       emit_v;
  logic [7:0] emit_d;

  always #2.5 clk = ~clk;

  pport_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rev_data(rev_data), .chr_valid(chr_valid), .chr_data(chr_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    emit_v = chr_valid; emit_d = chr_data;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    chk("R1 rdata", bus_rdata, 8'hFF);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 chr_valid", {7'd0, chr_valid}, 8'h00);
    rd_chk("R1 data", 3'd0, 8'hFF);
    rd_chk("R1 status", 3'd1, 8'hD9);
    rd_chk("R1 control", 3'd2, 8'hCC);
  endtask

  task automatic t_direction;
    wr(3'd0, 8'h12);
    wr(3'd2, 8'h2C);
    rd_chk("R2 forced bits", 3'd2, 8'hEC);
    rd_chk("R7 reverse read", 3'd0, 8'h3A);
    wr(3'd2, 8'h0C);
    rd_chk("R7 forward read", 3'd0, 8'h12);
  endtask

  task automatic t_print;
    wr(3'd0, 8'h41);
    wr(3'd2, 8'hCD);
    chk("R4 emit valid", {7'd0, emit_v}, 8'h01);
    chk("R4 emit data", emit_d, 8'h41);
    @(negedge clk);
    chk("R4 one-cycle pulse", {7'd0, chr_valid}, 8'h00);
    rd_chk("R4 busy cleared", 3'd1, 8'h59);
    wr(3'd2, 8'hCD);
    chk("R4 no re-emit", {7'd0, emit_v}, 8'h00);
    wr(3'd2, 8'hCC);
    rd_chk("R6 step ack", 3'd1, 8'h59);
    rd_chk("R6 step idle", 3'd1, 8'h19);
    rd_chk("R6 step done", 3'd1, 8'hD9);
    rd_chk("R6 stays", 3'd1, 8'hD9);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr(3'd2, 8'hDC);
    chk("R5 no irq w/o old enable", {7'd0, irq}, 8'h00);
    wr(3'd2, 8'hDD);
    wr(3'd2, 8'hDC);
    chk("R5 irq raised", {7'd0, irq}, 8'h01);
    wr(3'd0, 8'h55);
    chk("R10 data write keeps irq", {7'd0, irq}, 8'h01);
    rd(3'd1, v);
    chk("R6 status value", v, 8'h59);
    chk("R6 irq cleared", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_init;
    wr(3'd2, 8'h08);
    rd_chk("R3 init status", 3'd1, 8'hD8);
    rd_chk("R2 control", 3'd2, 8'hC8);
  endtask

  task automatic t_nosel;
    wr(3'd2, 8'hC4);
    wr(3'd2, 8'hC5);
    chk("R11 no emit", {7'd0, emit_v}, 8'h00);
    rd_chk("R11 status kept", 3'd1, 8'hD8);
    rd_chk("R11 control stored", 3'd2, 8'hC5);
  endtask

  task automatic t_unimpl;
    rd_chk("R8 ofs3", 3'd3, 8'hFF);
    rd_chk("R8 ofs5", 3'd5, 8'hFF);
    rd_chk("R8 ofs7", 3'd7, 8'hFF);
    wr(3'd1, 8'h00);
    rd_chk("R8 status write ignored", 3'd1, 8'hD8);
    wr(3'd4, 8'h00);
    wr(3'd6, 8'h00);
    rd_chk("R8 data kept", 3'd0, 8'h55);
    rd_chk("R8 control kept", 3'd2, 8'hC5);
  endtask

  task automatic t_rdtiming;
    rd_chk("R9 read", 3'd2, 8'hC5);
    rev_data = 8'h99;
    repeat (3) @(negedge clk);
    chk("R9 hold", bus_rdata, 8'hC5);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h77;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R9 read dropped on write", bus_rdata, 8'hC5);
    rd_chk("R9 write taken", 3'd0, 8'h77);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_print();
    t_irq();
    t_init();
    t_nosel();
    t_unimpl();
    t_rdtiming();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule